// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table held in memory. A request carries the virtual address and an access type (load or store). The walker fetches one word from the root table, then one word from the second-level table that the root word names. The root table's location comes from a frame number input. Both fetches go through a memory read port whose latency varies.

The virtual address has three fields. Bits 31:22 index the root table. Bits 21:12 index a 1024-entry second-level table, which covers 4 MiB of 4 KiB pages. Bits 11:0 are the byte offset within the page. Second-level tables only exist for regions in use, so a root word can say that its table is absent.

A walk ends in one of two ways:
- a physical address, formed from the leaf frame and the offset;
- a fault with a 2-bit reason code.

On a store to a writable page whose dirty flag is still clear, the walker writes the leaf word back to memory with the dirty flag set before it reports the result.

Top module: `vptw_walker`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `done_o`, `mem_rd_req_o` and `mem_wr_req_o` are 0.
- R2: The first read of a walk is at `{root_frame_i, va[31:22], 2'b00}`. The second read is at `{root_word[31:12], va[21:12], 2'b00}`.
- R3: If root word bit 0 (present) is 0, the walk reports fault code 2'b01 and issues no second-level read.
- R4: If leaf word bit 0 (present) is 0, the walk reports fault code 2'b10. This is the not-resident case.
- R5: On success the code is 2'b00 and `paddr_o` = `{leaf[31:12], va[11:0]}` in the `done_o` cycle. On any fault, `paddr_o` is 0.
- R6: A store to a present page with leaf bit 1 (writable) set and bit 6 (dirty) clear causes exactly one memory write before `done_o`. The write goes to the leaf address and carries the leaf word with bit 6 set.
- R7: A store to a present page whose bit 1 is 0 reports fault code 2'b11 and issues no memory write.
- R8: A load, or a store to a page whose bit 6 is already set, issues no memory write.
- R9: `done_o` is high for exactly one cycle per accepted request. `req_ready_o` is 0 from acceptance until after that cycle.
- R10: A memory request keeps its address and data stable while its ready input is low. Any latency, including zero wait cycles, gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| root_frame_i | input | 20 | Frame number of the root table |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle; request accepted when both are high |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_write_i | input | 1 | 1 = store access, 0 = load |
| mem_rd_req_o | output | 1 | Memory read request |
| mem_rd_addr_o | output | 32 | Byte address of the entry to read |
| mem_rd_ready_i | input | 1 | Read data valid this cycle; request consumed |
| mem_rd_data_i | input | 32 | Read data |
| mem_wr_req_o | output | 1 | Memory write request (dirty-flag update) |
| mem_wr_addr_o | output | 32 | Byte address of the leaf entry |
| mem_wr_data_o | output | 32 | Leaf entry with dirty flag set |
| mem_wr_ready_i | input | 1 | Write accepted this cycle |
| done_o | output | 1 | Result valid, one cycle |
| fault_o | output | 1 | Walk ended in a fault |
| fault_code_o | output | 2 | 00 ok, 01 root absent, 10 leaf absent, 11 write to read-only page |
| paddr_o | output | 32 | Physical address (0 on fault) |

## Verification
Faults in the state register or in the held entry show up at the ports within the walk they corrupt:
- A wrong branch after the root fetch shows as an extra or missing second-level read, or as a wrong fault code, on the `done_o` cycle of that request.
- A corrupted held leaf word shows as a wrong frame in `paddr_o`, or as wrong write-back data, one or two cycles after the leaf fetch completes.
- A lost dirty-flag decision shows as a missing or spurious write before `done_o`. It also shows on the next store to the same page, which must then write nothing.

// File: rtl/vptw_pkg.sv
package vptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_ROOT, ST_RD_LEAF, ST_WR_DIRTY, ST_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE        = 2'b00,
    FLT_ROOT_ABSENT = 2'b01,
    FLT_LEAF_ABSENT = 2'b10,
    FLT_WRITE_PROT  = 2'b11
  } fault_e;

  localparam int unsigned PTE_PRESENT_BIT  = 0;
  localparam int unsigned PTE_WRITABLE_BIT = 1;
  localparam int unsigned PTE_DIRTY_BIT    = 6;
endpackage

// File: rtl/vptw_addr_split.sv
module vptw_addr_split #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12,
  localparam int unsigned FRAME_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0]  va_i,
  input  logic [FRAME_W-1:0] root_frame_i,
  input  logic [FRAME_W-1:0] table_frame_i,
  output logic [ADDR_W-1:0]  root_ea_o,
  output logic [ADDR_W-1:0]  leaf_ea_o,
  output logic [OFF_W-1:0]   offset_o
);
  logic [IDX_W-1:0] root_idx, leaf_idx;

  assign root_idx = va_i[ADDR_W-1 -: IDX_W];
  assign leaf_idx = va_i[OFF_W +: IDX_W];
  assign offset_o = va_i[OFF_W-1:0];

  // entries are 4 bytes wide
  assign root_ea_o = {root_frame_i,  OFF_W'({root_idx, 2'b00})};
  assign leaf_ea_o = {table_frame_i, OFF_W'({leaf_idx, 2'b00})};
endmodule

// File: rtl/vptw_pte_decode.sv
module vptw_pte_decode
  import vptw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12,
  localparam int unsigned FRAME_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0]  pte_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               present_o,
  output logic               writable_o,
  output logic               dirty_o,
  output logic [ADDR_W-1:0]  marked_o
);
  assign frame_o    = pte_i[ADDR_W-1:OFF_W];
  assign present_o  = pte_i[PTE_PRESENT_BIT];
  assign writable_o = pte_i[PTE_WRITABLE_BIT];
  assign dirty_o    = pte_i[PTE_DIRTY_BIT];

  always_comb begin
    marked_o = pte_i;
    marked_o[PTE_DIRTY_BIT] = 1'b1;
  end
endmodule

// File: rtl/vptw_ctrl.sv
module vptw_ctrl
  import vptw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        write_q_i,
  input  logic        rd_ready_i,
  input  logic        wr_ready_i,
  input  logic        present_i,
  input  logic        writable_i,
  input  logic        dirty_i,
  output logic        req_ready_o,
  output logic        rd_req_o,
  output logic        rd_leaf_o,
  output logic        wr_req_o,
  output logic        ld_req_o,
  output logic        ld_table_o,
  output logic        ld_leaf_o,
  output logic        done_o,
  output logic [1:0]  fault_code_o
);
  walk_state_e state_q, state_d;
  fault_e      fault_q, fault_d;

  always_comb begin
    state_d = state_q;
    fault_d = fault_q;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        state_d = ST_RD_ROOT;
        fault_d = FLT_NONE;
      end
      ST_RD_ROOT: if (rd_ready_i) begin
        if (!present_i) begin
          fault_d = FLT_ROOT_ABSENT;
          state_d = ST_DONE;
        end else begin
          state_d = ST_RD_LEAF;
        end
      end
      ST_RD_LEAF: if (rd_ready_i) begin
        if (!present_i) begin
          fault_d = FLT_LEAF_ABSENT;
          state_d = ST_DONE;
        end else if (write_q_i && !writable_i) begin
          fault_d = FLT_WRITE_PROT;
          state_d = ST_DONE;
        end else if (write_q_i && !dirty_i) begin
          state_d = ST_WR_DIRTY;
        end else begin
          state_d = ST_DONE;
        end
      end
      ST_WR_DIRTY: if (wr_ready_i) state_d = ST_DONE;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fault_q <= FLT_NONE;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign rd_req_o     = (state_q == ST_RD_ROOT) || (state_q == ST_RD_LEAF);
  assign rd_leaf_o    = (state_q == ST_RD_LEAF);
  assign wr_req_o     = (state_q == ST_WR_DIRTY);
  assign done_o       = (state_q == ST_DONE);
  assign ld_req_o     = req_ready_o && req_valid_i;
  assign ld_table_o   = (state_q == ST_RD_ROOT) && rd_ready_i;
  assign ld_leaf_o    = (state_q == ST_RD_LEAF) && rd_ready_i;
  assign fault_code_o = fault_q;

  // R9: result strobe lasts one cycle
  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9: no acceptance while busy
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !rd_req_o && !wr_req_o && !done_o);
  // R6: the write-back only follows a completed leaf read
  p_wr_after_leaf_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_req_o) |-> $past(rd_leaf_o && rd_ready_i));
  // R7: protection fault never follows a write-back
  p_prot_no_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_code_o == FLT_WRITE_PROT) |-> !$past(wr_req_o));
  // R3: a root fault means the leaf table was never read
  p_root_fault_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_code_o == FLT_ROOT_ABSENT) |-> !$past(rd_leaf_o));
endmodule

// File: rtl/vptw_walker.sv
module vptw_walker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12,
  localparam int unsigned FRAME_W = ADDR_W - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FRAME_W-1:0] root_frame_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_vaddr_i,
  input  logic               req_write_i,
  output logic               mem_rd_req_o,
  output logic [ADDR_W-1:0]  mem_rd_addr_o,
  input  logic               mem_rd_ready_i,
  input  logic [ADDR_W-1:0]  mem_rd_data_i,
  output logic               mem_wr_req_o,
  output logic [ADDR_W-1:0]  mem_wr_addr_o,
  output logic [ADDR_W-1:0]  mem_wr_data_o,
  input  logic               mem_wr_ready_i,
  output logic               done_o,
  output logic               fault_o,
  output logic [1:0]         fault_code_o,
  output logic [ADDR_W-1:0]  paddr_o
);
  logic [ADDR_W-1:0]  va_q, leaf_pte_q, pte_view;
  logic               write_q;
  logic [FRAME_W-1:0] table_frame_q;

  logic ld_req, ld_table, ld_leaf, rd_leaf;
  logic [ADDR_W-1:0]  root_ea, leaf_ea, marked;
  logic [OFF_W-1:0]   offset;
  logic [FRAME_W-1:0] view_frame;
  logic view_present, view_writable, view_dirty;

  vptw_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
    .va_i          (va_q),
    .root_frame_i  (root_frame_i),
    .table_frame_i (table_frame_q),
    .root_ea_o     (root_ea),
    .leaf_ea_o     (leaf_ea),
    .offset_o      (offset)
  );

  // decode the live read word while fetching, the held leaf afterwards
  assign pte_view = mem_rd_req_o ? mem_rd_data_i : leaf_pte_q;

  vptw_pte_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_decode (
    .pte_i      (pte_view),
    .frame_o    (view_frame),
    .present_o  (view_present),
    .writable_o (view_writable),
    .dirty_o    (view_dirty),
    .marked_o   (marked)
  );

  vptw_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .write_q_i    (write_q),
    .rd_ready_i   (mem_rd_ready_i),
    .wr_ready_i   (mem_wr_ready_i),
    .present_i    (view_present),
    .writable_i   (view_writable),
    .dirty_i      (view_dirty),
    .req_ready_o  (req_ready_o),
    .rd_req_o     (mem_rd_req_o),
    .rd_leaf_o    (rd_leaf),
    .wr_req_o     (mem_wr_req_o),
    .ld_req_o     (ld_req),
    .ld_table_o   (ld_table),
    .ld_leaf_o    (ld_leaf),
    .done_o       (done_o),
    .fault_code_o (fault_code_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_q          <= '0;
      write_q       <= 1'b0;
      table_frame_q <= '0;
      leaf_pte_q    <= '0;
    end else begin
      if (ld_req) begin
        va_q    <= req_vaddr_i;
        write_q <= req_write_i;
      end
      if (ld_table) table_frame_q <= view_frame;
      if (ld_leaf)  leaf_pte_q    <= mem_rd_data_i;
    end
  end

  assign mem_rd_addr_o = rd_leaf ? leaf_ea : root_ea;
  assign mem_wr_addr_o = leaf_ea;
  assign mem_wr_data_o = marked;
  assign fault_o       = done_o && (fault_code_o != 2'b00);
  assign paddr_o       = (done_o && !fault_o) ? {view_frame, offset} : '0;

  // R10: read request holds its address until consumed
  p_rd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_req_o && !mem_rd_ready_i) |=> mem_rd_req_o && $stable(mem_rd_addr_o));
  // R10: write request holds address and data until consumed
  p_wr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_req_o && !mem_wr_ready_i) |=>
      mem_wr_req_o && $stable(mem_wr_addr_o) && $stable(mem_wr_data_o));
  // R6: write-back carries the dirty flag and a present entry
  p_wr_marked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_req_o |-> mem_wr_data_o[6] && mem_wr_data_o[0] && mem_wr_data_o[1]);
  // R2: read and write never overlap
  p_port_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_req_o && mem_wr_req_o));
endmodule

// File: tb/vptw_walker_tb_top.sv
module vptw_walker_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;  // 250 MHz

  localparam logic [19:0] ROOT_FRAME = 20'h00010;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, rd_req, wr_req, done, fault;
  logic [31:0] rd_addr, wr_addr, wr_data, paddr;
  logic [1:0]  fault_code;
  logic        rd_rdy = 1'b0, wr_rdy = 1'b0;
  logic [31:0] rd_data = '0;

  vptw_walker dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .root_frame_i(ROOT_FRAME),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .req_write_i(req_write),
    .mem_rd_req_o(rd_req), .mem_rd_addr_o(rd_addr),
    .mem_rd_ready_i(rd_rdy), .mem_rd_data_i(rd_data),
    .mem_wr_req_o(wr_req), .mem_wr_addr_o(wr_addr), .mem_wr_data_o(wr_data),
    .mem_wr_ready_i(wr_rdy),
    .done_o(done), .fault_o(fault), .fault_code_o(fault_code), .paddr_o(paddr)
  );

  int checks = 0, failures = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory model
  logic [31:0] mem [int unsigned];
  function automatic logic [31:0] mrd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  int lat = 0, rd_wait = 0, wr_wait = 0;
  logic [31:0] rd_log[$], wr_alog[$], wr_dlog[$];
  logic [31:0] rd_hold;

  always @(negedge clk_i) begin
    if (rd_rdy) begin
      rd_rdy = 1'b0; rd_wait = 0;
    end else if (rd_req) begin
      if (rd_wait > 0 && rd_addr != rd_hold) chk(0, "R10 rd addr hold", rd_addr, rd_hold);
      rd_hold = rd_addr;
      if (rd_wait >= lat) begin
        rd_rdy = 1'b1; rd_data = mrd(rd_addr); rd_log.push_back(rd_addr);
      end else rd_wait++;
    end else rd_wait = 0;

    if (wr_rdy) begin
      wr_rdy = 1'b0; wr_wait = 0;
    end else if (wr_req) begin
      if (wr_wait >= lat) begin
        wr_rdy = 1'b1; mem[wr_addr] = wr_data;
        wr_alog.push_back(wr_addr); wr_dlog.push_back(wr_data);
      end else wr_wait++;
    end else wr_wait = 0;
  end

  // scoreboard
  typedef struct {
    logic [1:0]  code;
    logic [31:0] paddr;
    string       tag;
  } exp_t;
  exp_t exp_q[$];
  exp_t mon_e;
  int   done_cnt = 0;
  logic done_prev = 1'b0;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (done_prev && done) chk(0, "R9 done width", 32'(done), 32'h0);
      if (done) begin
        if (exp_q.size() == 0) chk(0, "R9 unexpected done", 32'h1, 32'h0);
        else begin
          mon_e = exp_q.pop_front();
          chk(fault_code == mon_e.code, mon_e.tag, 32'(fault_code), 32'(mon_e.code));
          chk(paddr == mon_e.paddr, {mon_e.tag, " paddr R5"}, paddr, mon_e.paddr);
        end
        done_cnt++;
      end
      done_prev = done;
    end
  end

  task automatic walk(input logic [31:0] va, input logic wr, input int l, input string tag);
    exp_t e;
    logic [31:0] r_ea, root, l_ea, leaf;
    bit exp_wr;
    int start;
    r_ea = {ROOT_FRAME, va[31:22], 2'b00};
    root = mrd(r_ea);
    l_ea = {root[31:12], va[21:12], 2'b00};
    leaf = mrd(l_ea);
    exp_wr = 0;
    e.tag = tag; e.paddr = '0;
    if (!root[0]) e.code = 2'b01;
    else if (!leaf[0]) e.code = 2'b10;
    else if (wr && !leaf[1]) e.code = 2'b11;
    else begin
      e.code = 2'b00; e.paddr = {leaf[31:12], va[11:0]};
      exp_wr = wr && !leaf[6];
    end
    exp_q.push_back(e);
    rd_log.delete(); wr_alog.delete(); wr_dlog.delete();
    lat = l;
    start = done_cnt;
    @(negedge clk_i);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk_i);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, {tag, " R9 busy"}, 32'(req_ready), 32'h0);
    wait (done_cnt != start);
    @(negedge clk_i);
    // R2: read address sequence
    chk(rd_log.size() == (root[0] ? 2 : 1), {tag, " R2 read count"}, rd_log.size(), root[0] ? 2 : 1);
    if (rd_log.size() > 0) chk(rd_log[0] == r_ea, {tag, " R2 root ea"}, rd_log[0], r_ea);
    if (root[0] && rd_log.size() > 1) chk(rd_log[1] == l_ea, {tag, " R2 leaf ea"}, rd_log[1], l_ea);
    // R6/R7/R8: write-back
    chk(wr_alog.size() == (exp_wr ? 1 : 0), {tag, " R6 write count"}, wr_alog.size(), exp_wr ? 1 : 0);
    if (exp_wr && wr_alog.size() == 1) begin
      chk(wr_alog[0] == l_ea, {tag, " R6 write ea"}, wr_alog[0], l_ea);
      chk(wr_dlog[0] == (leaf | 32'h40), {tag, " R6 write data"}, wr_dlog[0], leaf | 32'h40);
    end
  endtask

  int cyc = 0;
  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000) begin
      chk(0, "R9 watchdog", 32'(cyc), 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // tables: root at 0x10000, one leaf table at 0x20000
    mem[32'h0001_0004] = 32'h0002_0001;   // root idx 1 present
    mem[32'h0001_0008] = 32'h0003_0000;   // root idx 2 absent
    mem[32'h0002_0014] = 32'hABCD_E003;   // idx5 present writable clean
    mem[32'h0002_0018] = 32'h1234_5002;   // idx6 not present
    mem[32'h0002_001C] = 32'h5555_5001;   // idx7 read-only
    mem[32'h0002_0020] = 32'h6666_6043;   // idx8 writable dirty
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'h1);
    chk(!done && !rd_req && !wr_req, "R1 idle outputs", {29'h0, done, rd_req, wr_req}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready == 1'b1, "R1 ready after release", 32'(req_ready), 32'h1);

    walk(32'h0040_5123, 1'b0, 0, "R5 load ok");
    walk(32'h0040_5ABC, 1'b1, 2, "R6 store clean");
    chk(mrd(32'h0002_0014) == 32'hABCD_E043, "R6 leaf marked", mrd(32'h0002_0014), 32'hABCD_E043);
    walk(32'h0040_5004, 1'b1, 1, "R8 store already dirty");
    walk(32'h0080_1000, 1'b0, 1, "R3 root absent");
    walk(32'h0040_6FFF, 1'b1, 0, "R4 leaf absent");
    walk(32'h0040_7010, 1'b1, 3, "R7 read-only store");
    chk(mrd(32'h0002_001C) == 32'h5555_5001, "R7 leaf untouched", mrd(32'h0002_001C), 32'h5555_5001);
    walk(32'h0040_7010, 1'b0, 0, "R8 read-only load");
    walk(32'h0040_8777, 1'b1, 0, "R8 dirty store");
    walk(32'h0040_5FFF, 1'b0, 6, "R10 long latency");
    walk(32'h0000_0000, 1'b0, 0, "R3 root idx0 absent");
    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R9 all results seen", exp_q.size(), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule